// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked user port and an asynchronous 128K x 8 static RAM. A user raises a request strobe with a write flag, a 17-bit word address and, for writes, a data byte. The sequencer turns each request into a correctly timed pin sequence on the memory side. For a read it returns the captured byte; for either kind of access it raises a one-cycle completion pulse. A ready output tells the user when a new request can be taken.

Every phase length comes from nanosecond timing parameters and a clock-period parameter. Each phase lasts the ceiling of its nanosecond value divided by the clock period, and never less than one cycle. The memory has two select inputs of opposite polarity: an active-low select that frames each access and an active-high enable that stays high whenever the block is out of reset. The bidirectional data bus is split into an outgoing byte, an incoming byte and a drive-enable. The sequencer drives the bus only while the write strobe is low. A read uses the output enable, and a write uses the write strobe.

Top module: `sram_ctl`

## Requirements
- R1: While the synchronous reset is sampled high, the memory controls sit at their inactive levels from the next clock edge: select_n=1, enable=0, write_n=1, output_enable_n=1, bus drive=0. done=0 and ready=0.
- R2: Out of reset and with no access in progress, the outputs are select_n=1, enable=1, write_n=1, output_enable_n=1 and bus drive=0, and ready=1.
- R3: A read accepted at a clock edge presents the address with select_n=0 and output_enable_n=0 (write_n=1, bus not driven) for ACC cycles. ACC = max(1, ceil(max(T_AA_NS, T_OE_NS)/CLK_NS)), which is 3 with the defaults.
- R4: Read data is sampled at the clock edge that ends the last of the ACC cycles, never earlier. In the next cycle rd_data holds that byte and done=1 for exactly one cycle.
- R5: After a read, select_n and output_enable_n go back to 1 for TURN = max(1, ceil(T_OHZ_NS/CLK_NS)) cycles (1 by default) before the block is idle again. ready stays 0 throughout.
- R6: A write accepted at a clock edge holds select_n=0, write_n=0 and output_enable_n=1 for WP = max(1, ceil(max(T_WP_NS, T_DS_NS)/CLK_NS)) cycles (2 by default). During those cycles the bus drive is 1 and the outgoing byte equals the request data.
- R7: A write pulse is followed by REC cycles with write_n=1, select_n=1 and the bus released, and done=1 in the first of them. REC = max(1, ceil(T_WPH_NS/CLK_NS), ceil(T_WC_NS/CLK_NS) - WP), which is 1 by default.
- R8: done is never high in two consecutive cycles, and each accepted request yields exactly one done.
- R9: ready is 1 only when idle. A request held high while ready=0 starts no access until ready returns to 1, and the access then uses the fields present at that edge.
- R10: The bus is never driven while output_enable_n=0, nor in the cycle after output_enable_n rises.
- R11: The memory address does not change while select_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Request can be taken |
| mem_addr | output | 17 | Memory address bus |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_ce | output | 1 | Memory enable, active high |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte seen on the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
Two events can fall in the same cycle: the completion of one access (done with the last recovery or turnaround cycle) and the arrival of a new request. The bench provokes this by holding req high for many cycles while changing the write flag, address and data every cycle. Each request then meets the end of the previous access. The model accepts a request only in a cycle it predicts as idle and takes the fields present at that edge. It checks every cycle that ready, the strobes and the bus drive match. A memory model returns a wrong byte until ACC cycles of stable output enable have passed, and it flags any bus contention within a cycle of output enable, so a capture taken too early or a turnaround that is too short is caught.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RD_ACCESS = 3'd1,
    ST_RD_CAPT   = 3'd2,
    ST_WR_PULSE  = 3'd3,
    ST_WR_RECOV  = 3'd4
  } st_e;

  typedef struct packed {
    logic cs_n;
    logic ce;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic done;
  } pins_t;

  localparam pins_t PINS_OFF = '{cs_n: 1'b1, ce: 1'b0, we_n: 1'b1,
                                 oe_n: 1'b1, dq_oe: 1'b0, done: 1'b0};

  // ceiling of ns / clk_ns, at least one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // recovery = enough high time and enough total cycle time
  function automatic int unsigned recov_cyc(input int unsigned wph_cyc,
                                            input int unsigned wc_cyc,
                                            input int unsigned wp_cyc);
    int unsigned rest;
    rest = (wc_cyc > wp_cyc) ? (wc_cyc - wp_cyc) : 1;
    return umax(umax(wph_cyc, rest), 1);
  endfunction

  // pin levels for the cycle spent in state s; first marks phase entry
  function automatic pins_t pins_for(input st_e s, input logic first);
    pins_t p;
    p = '{cs_n: 1'b1, ce: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, done: 1'b0};
    case (s)
      ST_RD_ACCESS: begin
        p.cs_n = 1'b0;
        p.oe_n = 1'b0;
      end
      ST_RD_CAPT:   p.done = first;
      ST_WR_PULSE: begin
        p.cs_n  = 1'b0;
        p.we_n  = 1'b0;
        p.dq_oe = 1'b1;
      end
      ST_WR_RECOV:  p.done = first;
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctl_phase.sv
module sram_ctl_phase
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ACC_CYC  = 3,
  parameter int unsigned TURN_CYC = 1,
  parameter int unsigned WP_CYC   = 2,
  parameter int unsigned REC_CYC  = 1,
  parameter int unsigned CNT_W    = 2
) (
  input  logic clk,
  input  logic rst,
  input  st_e  state_q,
  input  st_e  state_d,
  output logic phase_last
);

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      len_m1;

  always_comb begin
    case (state_q)
      ST_RD_ACCESS: len_m1 = ACC_CYC - 1;
      ST_RD_CAPT:   len_m1 = TURN_CYC - 1;
      ST_WR_PULSE:  len_m1 = WP_CYC - 1;
      ST_WR_RECOV:  len_m1 = REC_CYC - 1;
      default:      len_m1 = 32'd0;
    endcase
  end

  assign phase_last = (32'(cnt_q) == len_m1);

  always_ff @(posedge clk) begin
    if (rst || (state_d != state_q)) cnt_q <= '0;
    else if (!phase_last)            cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic req_wr,
  input  logic ready,
  input  logic phase_last,
  output st_e  state_q,
  output st_e  state_d,
  output logic accept,
  output logic capture
);

  assign accept  = req && ready;
  assign capture = (state_q == ST_RD_ACCESS) && phase_last;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (accept) state_d = req_wr ? ST_WR_PULSE : ST_RD_ACCESS;
      ST_RD_ACCESS: if (phase_last) state_d = ST_RD_CAPT;
      ST_RD_CAPT:   if (phase_last) state_d = ST_IDLE;
      ST_WR_PULSE:  if (phase_last) state_d = ST_WR_RECOV;
      ST_WR_RECOV:  if (phase_last) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/sram_ctl_io.sv
module sram_ctl_io
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  st_e               state_q,
  input  st_e               state_d,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output pins_t             pins_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  // registered pins: no decode glitches reach the memory
  always_ff @(posedge clk) begin
    if (rst) pins_q <= PINS_OFF;
    else     pins_q <= pins_for(state_d, state_d != state_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (capture) rdata_q <= dq_in;
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_AA_NS  = 30,
  parameter int unsigned T_OE_NS  = 7,
  parameter int unsigned T_OHZ_NS = 9,
  parameter int unsigned T_WP_NS  = 20,
  parameter int unsigned T_DS_NS  = 15,
  parameter int unsigned T_WPH_NS = 5,
  parameter int unsigned T_WC_NS  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int unsigned ACC_CYC  = ns_to_cyc(umax(T_AA_NS, T_OE_NS), CLK_NS);
  localparam int unsigned TURN_CYC = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int unsigned WP_CYC   = ns_to_cyc(umax(T_WP_NS, T_DS_NS), CLK_NS);
  localparam int unsigned REC_CYC  = recov_cyc(ns_to_cyc(T_WPH_NS, CLK_NS),
                                               ns_to_cyc(T_WC_NS, CLK_NS), WP_CYC);
  localparam int unsigned MAX_CYC  = umax(umax(ACC_CYC, TURN_CYC), umax(WP_CYC, REC_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  st_e   state_q, state_d;
  logic  phase_last;
  logic  accept;
  logic  capture;
  pins_t pins_q;

  // idle and out of reset (enable high marks reset released)
  assign ready = (state_q == ST_IDLE) && pins_q.ce;

  sram_ctl_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .req_wr     (req_wr),
    .ready      (ready),
    .phase_last (phase_last),
    .state_q    (state_q),
    .state_d    (state_d),
    .accept     (accept),
    .capture    (capture)
  );

  sram_ctl_phase #(
    .ACC_CYC  (ACC_CYC),
    .TURN_CYC (TURN_CYC),
    .WP_CYC   (WP_CYC),
    .REC_CYC  (REC_CYC),
    .CNT_W    (CNT_W)
  ) u_phase (
    .clk        (clk),
    .rst        (rst),
    .state_q    (state_q),
    .state_d    (state_d),
    .phase_last (phase_last)
  );

  sram_ctl_io #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_io (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .state_d   (state_d),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (mem_dq_in),
    .pins_q    (pins_q),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .rdata_q   (rd_data)
  );

  assign mem_cs_n  = pins_q.cs_n;
  assign mem_ce    = pins_q.ce;
  assign mem_we_n  = pins_q.we_n;
  assign mem_oe_n  = pins_q.oe_n;
  assign mem_dq_oe = pins_q.dq_oe;
  assign done      = pins_q.done;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned ACC_CYC = 3,
  parameter int unsigned WP_CYC  = 2,
  parameter int unsigned REC_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              done,
  input logic              capture,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  localparam int unsigned SAT = 1000;

  int unsigned we_lo_q, we_hi_q, oe_lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_q <= 0;
      we_hi_q <= 0;
      oe_lo_q <= 0;
    end else begin
      we_lo_q <= !mem_we_n ? ((we_lo_q < SAT) ? we_lo_q + 1 : we_lo_q) : 0;
      we_hi_q <=  mem_we_n ? ((we_hi_q < SAT) ? we_hi_q + 1 : we_hi_q) : 0;
      oe_lo_q <= !mem_oe_n ? ((oe_lo_q < SAT) ? oe_lo_q + 1 : oe_lo_q) : 0;
    end
  end

  // R3
  rd_access_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_lo_q >= ACC_CYC));

  // R4
  capture_time_chk: assert property (@(posedge clk) disable iff (rst)
    capture |-> (!mem_oe_n && (oe_lo_q == ACC_CYC - 1)));

  // R6
  we_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_q >= WP_CYC));

  // R6
  bus_only_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && !mem_cs_n));

  // R7
  we_high_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> (we_hi_q >= REC_CYC));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_cs_n && mem_we_n && mem_oe_n));

  // R10
  no_drive_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || $past(!mem_oe_n)) |-> !mem_dq_oe);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W  (ADDR_W),
  .ACC_CYC (ACC_CYC),
  .WP_CYC  (WP_CYC),
  .REC_CYC (REC_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .done      (done),
  .capture   (capture),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

  localparam int AW = 17;
  localparam int DW = 8;

  function automatic int cyc(input int ns);
    int c;
    c = ns / 10;
    if (ns % 10 != 0) c = c + 1;
    return (c < 1) ? 1 : c;
  endfunction

  // phase lengths restated from the requirements
  localparam int ACC  = cyc(30);              // R3
  localparam int TURN = cyc(9);               // R5
  localparam int WP   = cyc(20);              // R6
  localparam int REC  = (cyc(25) - WP > cyc(5)) ? cyc(25) - WP : cyc(5);  // R7

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rd_data, mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;
  logic done, ready, mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;

  always #5 clk = ~clk;

  sram_ctl u_dut (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .ready(ready),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  typedef struct {
    bit cs_n, we_n, oe_n, dq_oe, done, is_rd;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int tag;
  } exp_t;

  exp_t q[$];
  logic [DW-1:0] gold[int];
  logic [DW-1:0] mem[int];
  int total = 0, bad = 0;
  bit rst_seen = 1'b1;
  bit m_ready = 1'b0;
  bit finished = 1'b0;

  // memory model state
  int age = 0;
  bit drive_prev = 1'b0;
  bit wpend = 1'b0;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd;

  function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : dflt(a);
  endfunction

  function automatic logic [DW-1:0] gold_rd(input logic [AW-1:0] a);
    return gold.exists(int'(a)) ? gold[int'(a)] : dflt(a);
  endfunction

  task automatic chk(input bit ok, input int tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) rst_seen <= rst;

  // acceptance as predicted by the model
  always @(posedge clk) begin
    if (!rst && req && m_ready) begin
      if (req_wr) begin
        gold[int'(req_addr)] = req_wdata;
        for (int i = 0; i < WP; i++)        // R6
          q.push_back('{cs_n:0, we_n:0, oe_n:1, dq_oe:1, done:0, is_rd:0,
                        a:req_addr, d:req_wdata, tag:6});
        for (int i = 0; i < REC; i++)       // R7
          q.push_back('{cs_n:1, we_n:1, oe_n:1, dq_oe:0, done:(i == 0), is_rd:0,
                        a:req_addr, d:req_wdata, tag:7});
      end else begin
        for (int i = 0; i < ACC; i++)       // R3
          q.push_back('{cs_n:0, we_n:1, oe_n:0, dq_oe:0, done:0, is_rd:0,
                        a:req_addr, d:'0, tag:3});
        for (int i = 0; i < TURN; i++)      // R4, R5
          q.push_back('{cs_n:1, we_n:1, oe_n:1, dq_oe:0, done:(i == 0), is_rd:(i == 0),
                        a:req_addr, d:gold_rd(req_addr), tag:(i == 0) ? 4 : 5});
      end
    end
  end

  // per-cycle comparison and memory model
  always @(negedge clk) begin
    exp_t e;
    bit popped;
    bit drive;
    if (rst_seen) begin
      q.delete();
      m_ready = 1'b0;
      // R1
      chk(mem_cs_n == 1'b1 && mem_we_n == 1'b1 && mem_oe_n == 1'b1, 1, "reset strobes",
          {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
      chk(mem_ce == 1'b0 && mem_dq_oe == 1'b0, 1, "reset ce/drive", {mem_ce, mem_dq_oe}, 0);
      chk(done == 1'b0 && ready == 1'b0, 1, "reset done/ready", {done, ready}, 0);
    end else begin
      popped = (q.size() > 0);
      if (popped) e = q.pop_front();
      else e = '{cs_n:1, we_n:1, oe_n:1, dq_oe:0, done:0, is_rd:0, a:'0, d:'0, tag:2}; // R2
      m_ready = !popped;
      chk(mem_cs_n == e.cs_n, e.tag, "cs_n", mem_cs_n, e.cs_n);
      chk(mem_we_n == e.we_n, e.tag, "we_n", mem_we_n, e.we_n);
      chk(mem_oe_n == e.oe_n, e.tag, "oe_n", mem_oe_n, e.oe_n);
      chk(mem_dq_oe == e.dq_oe, e.tag, "dq_oe", mem_dq_oe, e.dq_oe);
      chk(mem_ce == 1'b1, 2, "ce", mem_ce, 1);
      chk(done == e.done, 8, "done", done, e.done);                  // R8
      chk(ready == !popped, 9, "ready", ready, !popped);             // R9
      if (!e.cs_n) chk(mem_addr == e.a, 11, "addr", mem_addr, e.a);  // R11
      if (e.dq_oe) chk(mem_dq_out == e.d, 6, "wdata", mem_dq_out, e.d);
      if (e.is_rd) chk(rd_data == e.d, 4, "rd_data", rd_data, e.d);  // R4
    end
    // memory model: drives only after ACC stable cycles, keeps driving one cycle after release
    drive = !mem_cs_n && mem_ce && mem_we_n && !mem_oe_n;
    chk(!(mem_dq_oe && (drive || drive_prev)), 10, "bus contention",
        {mem_dq_oe, drive, drive_prev}, 0);                          // R10
    drive_prev = drive;
    age = drive ? age + 1 : 0;
    mem_dq_in <= (drive && age >= ACC) ? mem_rd(mem_addr) : ~mem_rd(mem_addr);
    if (!mem_we_n && !mem_cs_n && mem_ce) begin
      wpend = 1'b1;
      wa = mem_addr;
      wd = mem_dq_oe ? mem_dq_out : ~mem_dq_out;
    end else if (wpend && mem_we_n) begin
      mem[int'(wa)] = wd;
      wpend = 1'b0;
    end
  end

  task automatic op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    #1;
    req = 1'b1; req_wr = w; req_addr = a; req_wdata = d;
    forever begin
      @(posedge clk);
      if (m_ready) break;
    end
    #1 req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    repeat (3) @(negedge clk);                       // R2 idle
    op(1'b1, 17'h00010, 8'h5A);                      // R6, R7
    op(1'b0, 17'h00010, 8'h00);                      // R3, R4
    op(1'b0, 17'h00777, 8'h00);                      // unwritten location
    op(1'b1, 17'h1FFFF, 8'hFF);
    op(1'b1, 17'h00000, 8'h00);
    op(1'b0, 17'h1FFFF, 8'h00);
    op(1'b0, 17'h00000, 8'h00);
    op(1'b0, 17'h00010, 8'h00);                      // read then write: R10, R5
    op(1'b1, 17'h00020, 8'hC3);
    op(1'b0, 17'h00020, 8'h00);
    // R9: request held high across busy cycles, fields changing every cycle
    @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      #1;
      req = 1'b1;
      req_wr = (i % 3 != 0);
      req_addr = AW'(100 + (i % 8));
      req_wdata = DW'(i * 7 + 1);
      @(negedge clk);
    end
    #1 req = 1'b0;
    for (int i = 0; i < 8; i++) op(1'b0, AW'(100 + i), 8'h00);
    // R1: reset in the middle of a write pulse
    op(1'b1, 17'h00400, 8'h99);
    #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    op(1'b0, 17'h00010, 8'h00);
    repeat (6) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule